// File: doc/BRIEF.md
# Eight-Lane YCbCr to RGB Colour Converter

This block converts a stream of YCbCr pixels into RGB, eight pixels on every accepted beat. Each pixel has its luma offset (16) and chroma offsets (128) removed to form signed 16-bit operands. Those operands are multiplied by a programmable 3x3 matrix of signed 18-bit coefficients with 16 fractional bits. The three products in each row are summed, a half-LSB rounding constant is added, the result is shifted right by 16 and clamped to 0..255.

Beats enter through a valid/ready handshake and leave through another one. The pipeline has three register stages. When the consumer holds ready low, the whole pipeline freezes and nothing is lost or repeated. A small write port replaces any of the nine coefficients. After reset the coefficients hold studio-range BT.601 values, so the block works before any write.

Top module: `ycc2rgb_x8`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is low until a beat has been accepted. The coefficients reset to: Y column 76309 in all three rows, R-from-Cr 104597, G-from-Cb -25675, G-from-Cr -53279, B-from-Cb 131071, and the others 0.
- R2: Before multiplication, 16 is subtracted from each Y sample and 128 from each Cb and Cr sample, giving signed values. An input of Y=16, Cb=Cr=128 therefore yields R=G=B=0.
- R3: Each output channel is the sum over the Y, Cb and Cr columns of coefficient times offset sample. The coefficient at address 3*row+col holds row 0=R, 1=G, 2=B and col 0=Y, 1=Cb, 2=Cr.
- R4: Before the descale, 32768 is added to each row sum. The sum is then arithmetically shifted right by 16, so a result exactly halfway between two integers rounds up.
- R5: Each shifted result below 0 becomes 0, and each result above 255 becomes 255.
- R6: Lane i of every pixel bus occupies bits [8i+7:8i]. The eight lanes are converted independently with the same coefficients.
- R7: With out_ready high, a beat presented with in_valid and in_ready high in cycle c appears with out_valid high in cycle c+3.
- R8: While out_valid is high and out_ready is low, in_ready is low and the outputs hold. Every accepted beat is delivered exactly once, in order.
- R9: A write with cfg_we high and cfg_addr 0..8 loads cfg_data, read as signed 18-bit, into that coefficient. Beats accepted after the write, with the pipeline empty at the time of the write, use the new value. The full range -131072..131071 is usable.
- R10: A write to cfg_addr 9..15 changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_y | input | 64 | Eight luma samples |
| in_cb | input | 64 | Eight blue-difference samples |
| in_cr | input | 64 | Eight red-difference samples |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_r | output | 64 | Eight red samples |
| out_g | output | 64 | Eight green samples |
| out_b | output | 64 | Eight blue samples |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient index |
| cfg_data | input | 18 | Signed coefficient value |

## Verification
The bench sweeps every luma value against varied chroma on all lanes. It compares each result with an arithmetic model, so a wrong offset or a swapped matrix column shows up as shifted colours. A coefficient of 0.5 and a negative luma gain test the half-way case and both saturation ends: a design that truncated instead of rounding would come out one low on odd inputs, and one that wrapped instead of clamping would output large values for dark pixels. Irregular back-pressure would expose lost or duplicated beats in a stall path that let the pipeline slip. Writes to unused addresses would alter the conversion if the address decode aliased them onto real coefficients.

// File: rtl/ycc2rgb_x8.sv
module ycc2rgb_x8 #(
  parameter int LANES = 8,
  parameter int PIX_W = 8,
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int FRAC  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_y,
  input  logic [LANES*PIX_W-1:0] in_cb,
  input  logic [LANES*PIX_W-1:0] in_cr,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*PIX_W-1:0] out_r,
  output logic [LANES*PIX_W-1:0] out_g,
  output logic [LANES*PIX_W-1:0] out_b,
  input  logic                   cfg_we,
  input  logic [3:0]             cfg_addr,
  input  logic [CW-1:0]          cfg_data
);
  localparam int NC   = 9;
  localparam int PW   = DW + CW;
  localparam int SW   = PW + 2;
  localparam int RW   = SW - FRAC;
  localparam logic signed [SW-1:0] RND   = SW'(64'd1 << (FRAC - 1));
  localparam logic signed [RW-1:0] MAXV  = RW'((1 << PIX_W) - 1);
  localparam logic signed [DW-1:0] Y_OFS = DW'(16 << (PIX_W - 8));
  localparam logic signed [DW-1:0] C_OFS = DW'(1 << (PIX_W - 1));

  function automatic logic signed [CW-1:0] coef_init(int k);
    case (k)
      0, 3, 6: return CW'(76309);
      2:       return CW'(104597);
      4:       return CW'(-25675);
      5:       return CW'(-53279);
      7:       return CW'(131071);
      default: return '0;
    endcase
  endfunction

  logic signed [CW-1:0] coef [NC];
  logic v1, v2, v3, adv;

  assign adv       = !v3 || out_ready;
  assign in_ready  = adv;
  assign out_valid = v3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++) coef[k] <= coef_init(k);
    end else if (cfg_we && 32'(cfg_addr) < NC) begin
      coef[cfg_addr] <= $signed(cfg_data);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [DW-1:0] d [3];
    logic signed [PW-1:0] p [NC];
    logic signed [SW-1:0] acc [3];
    logic signed [RW-1:0] sh [3];
    logic [PIX_W-1:0]     sat [3];
    logic [PIX_W-1:0]     q [3];

    always_ff @(posedge clk) begin
      if (adv) begin
        d[0] <= $signed(DW'(in_y [l*PIX_W +: PIX_W])) - Y_OFS;
        d[1] <= $signed(DW'(in_cb[l*PIX_W +: PIX_W])) - C_OFS;
        d[2] <= $signed(DW'(in_cr[l*PIX_W +: PIX_W])) - C_OFS;
      end
    end

    always_ff @(posedge clk) begin
      if (adv) begin
        for (int k = 0; k < NC; k++) p[k] <= PW'(d[k % 3]) * PW'(coef[k]);
      end
    end

    always_comb begin
      for (int r = 0; r < 3; r++) begin
        acc[r] = SW'(p[3*r]) + SW'(p[3*r+1]) + SW'(p[3*r+2]) + RND;
        sh[r]  = RW'(acc[r] >>> FRAC);
        if (sh[r] < 0)         sat[r] = '0;
        else if (sh[r] > MAXV) sat[r] = '1;
        else                   sat[r] = sh[r][PIX_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (adv) begin
        for (int r = 0; r < 3; r++) q[r] <= sat[r];
      end
    end

    assign out_r[l*PIX_W +: PIX_W] = q[0];
    assign out_g[l*PIX_W +: PIX_W] = q[1];
    assign out_b[l*PIX_W +: PIX_W] = q[2];
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> v1);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b));

  // R9
  coef_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && 32'(cfg_addr) < NC |=> coef[$past(cfg_addr)] == $signed($past(cfg_data)));

  // R10
  coef_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && 32'(cfg_addr) >= NC |=> $stable(coef[0]) && $stable(coef[NC-1]));
endmodule

// File: tb/ycc2rgb_x8_tb_top.sv
module ycc2rgb_x8_tb_top;
  localparam int CLK_P = 10;
  localparam int L = 8;
  localparam int BW = L * 8;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b1, cfg_we = 1'b0;
  logic in_ready, out_valid;
  logic [BW-1:0] in_y = '0, in_cb = '0, in_cr = '0, out_r, out_g, out_b;
  logic [3:0] cfg_addr = '0;
  logic [17:0] cfg_data = '0;

  ycc2rgb_x8 dut_i (.clk, .rst_n, .in_valid, .in_ready, .in_y, .in_cb, .in_cr,
    .out_valid, .out_ready, .out_r, .out_g, .out_b, .cfg_we, .cfg_addr, .cfg_data);

  int pass_n = 0, total_n = 0;
  longint cm [9] = '{76309, 0, 104597, 76309, -25675, -53279, 76309, 131071, 0};
  logic [3*BW-1:0] expq [$];
  string tagq [$];
  bit stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what);
    total_n++;
    if (ok) pass_n++;
    else $display("FAIL %s: %s", tag, what);
  endtask

  function automatic int conv(int y, int cb, int cr, int row);
    longint s;
    s = cm[3*row]*(y-16) + cm[3*row+1]*(cb-128) + cm[3*row+2]*(cr-128) + 32768;
    s = s >>> 16;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return int'(s);
  endfunction

  function automatic logic [3*BW-1:0] expect_beat(logic [BW-1:0] y, logic [BW-1:0] cb, logic [BW-1:0] cr);
    logic [BW-1:0] r, g, b;
    for (int l = 0; l < L; l++) begin
      r[l*8 +: 8] = 8'(conv(int'(y[l*8 +: 8]), int'(cb[l*8 +: 8]), int'(cr[l*8 +: 8]), 0));
      g[l*8 +: 8] = 8'(conv(int'(y[l*8 +: 8]), int'(cb[l*8 +: 8]), int'(cr[l*8 +: 8]), 1));
      b[l*8 +: 8] = 8'(conv(int'(y[l*8 +: 8]), int'(cb[l*8 +: 8]), int'(cr[l*8 +: 8]), 2));
    end
    return {r, g, b};
  endfunction

  task automatic send(input logic [BW-1:0] y, input logic [BW-1:0] cb, input logic [BW-1:0] cr, input string tag);
    bit acc;
    in_y = y; in_cb = cb; in_cr = cr; in_valid = 1'b1;
    do begin
      #1 acc = in_ready;
      if (acc) begin
        expq.push_back(expect_beat(y, cb, cr));
        tagq.push_back(tag);
      end
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (expq.size() != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input int a, input longint d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_data = 18'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 9) cm[a] = d;
  endtask

  task automatic sweep(input int seed, input string tag);
    logic [BW-1:0] y, cb, cr;
    for (int v = 0; v < 256; v++) begin
      for (int l = 0; l < L; l++) begin
        y[l*8 +: 8]  = 8'(v + l * seed);
        cb[l*8 +: 8] = 8'(v * 5 + l * 37 + seed);
        cr[l*8 +: 8] = 8'(v * 11 + l * 71 + 3 * seed);
      end
      send(y, cb, cr, tag);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_mode ? (lfsr[0] | lfsr[3]) & ~lfsr[5] : 1'b1;
  end

  logic [3*BW-1:0] held;
  bit was_stalled = 0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (was_stalled)
        chk(out_valid && {out_r, out_g, out_b} == held, "R8",
            $sformatf("hold lost act=%h exp=%h", {out_r, out_g, out_b}, held));
      was_stalled = 0;
      if (rst_n && out_valid && !out_ready) begin
        chk(!in_ready, "R8", $sformatf("in_ready act=%0b exp=0 while stalled", in_ready));
        held = {out_r, out_g, out_b};
        was_stalled = 1;
      end
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) chk(0, "R8", "act=extra beat exp=none");
        else begin
          logic [3*BW-1:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk({out_r, out_g, out_b} == e, t,
              $sformatf("act=%h exp=%h", {out_r, out_g, out_b}, e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "act=timeout exp=finish");
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end

  initial begin
    bit s1, s2, s3;
    logic [BW-1:0] y, cb, cr;
    repeat (3) @(negedge clk);
    #1 chk(!out_valid, "R1", $sformatf("out_valid in reset act=%0b exp=0", out_valid));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(!out_valid, "R1", $sformatf("out_valid after reset act=%0b exp=0", out_valid));
    @(negedge clk);

    // R2: black level input gives zero on every channel
    send({L{8'd128}} & '0 | {L{8'd16}}, {L{8'd128}}, {L{8'd128}}, "R2");
    // R1 R3 R6: default coefficients, full luma sweep
    sweep(32, "R3");
    sweep(7, "R6");
    // R5: extremes per lane
    y  = {8'd235, 8'd16, 8'd255, 8'd0, 8'd235, 8'd16, 8'd255, 8'd0};
    cb = {8'd255, 8'd0, 8'd0, 8'd255, 8'd240, 8'd128, 8'd255, 8'd0};
    cr = {8'd0, 8'd255, 8'd0, 8'd255, 8'd240, 8'd128, 8'd255, 8'd0};
    send(y, cb, cr, "R5");
    drain();

    // R7: isolated beat latency
    in_y = {L{8'd100}}; in_cb = {L{8'd90}}; in_cr = {L{8'd200}}; in_valid = 1'b1;
    #1 chk(in_ready, "R7", $sformatf("in_ready act=%0b exp=1", in_ready));
    expq.push_back(expect_beat(in_y, in_cb, in_cr));
    tagq.push_back("R7");
    @(negedge clk); in_valid = 1'b0; #2 s1 = out_valid;
    @(negedge clk); #2 s2 = out_valid;
    @(negedge clk); #2 s3 = out_valid;
    chk(!s1 && !s2 && s3, "R7", $sformatf("valid by cycle act=%0b%0b%0b exp=001", s1, s2, s3));
    drain();

    // R8: irregular back-pressure
    stall_mode = 1;
    for (int n = 0; n < 200; n++) begin
      for (int l = 0; l < L; l++) begin
        y[l*8 +: 8] = 8'(n * 3 + l); cb[l*8 +: 8] = 8'(n * 7 + l * 13); cr[l*8 +: 8] = 8'(255 - n - l);
      end
      send(y, cb, cr, "R8");
    end
    drain();
    stall_mode = 0;
    chk(expq.size() == 0, "R8", $sformatf("undelivered act=%0d exp=0", expq.size()));
    drain();

    // R4 R9: rounding and negative gain
    wr(0, 32768); wr(1, 0); wr(2, 0);
    wr(3, -65536); wr(4, 0); wr(5, 0);
    wr(6, 0); wr(7, 98304); wr(8, -32768);
    drain();
    sweep(1, "R4");
    drain();
    // R9: coefficient range extremes
    wr(0, 131071); wr(1, -131072); wr(2, 0);
    wr(3, -131072); wr(4, 0); wr(5, 131071);
    drain();
    sweep(19, "R9");
    drain();

    // R10: writes beyond the matrix change nothing
    for (int a = 9; a < 16; a++) wr(a, 18'h1FFFF);
    drain();
    for (int n = 0; n < 32; n++) begin
      for (int l = 0; l < L; l++) begin
        y[l*8 +: 8] = 8'(n * 8 + l); cb[l*8 +: 8] = 8'(n * 9 + l * 5); cr[l*8 +: 8] = 8'(n * 17 + l * 3);
      end
      send(y, cb, cr, "R10");
    end
    drain();

    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end
endmodule